// File: doc/BRIEF.md
# Processor low-power state sequencer

This block is a synchronous controller that follows the low-power state of a processor core. It starts in Stop-Grant and moves to Sleep when the active-low sleep request is asserted. From Sleep only, an asserted deep-sleep request moves it into Deep Sleep. Releasing that request starts a PLL-relock wait. Sleep is reported again only after a programmed interval of reference-clock cycles. Releasing the sleep request while in Sleep returns the block to Stop-Grant.

The block drives a bus-clock gate enable. That enable turns off a fixed, short number of cycles after Deep Sleep is entered with the clock-stop request asserted. It turns back on a programmed delay after Deep Sleep is left. The counters run on a free-running reference clock, so timing keeps going while the bus clock is gated. A snoop/interrupt acceptance flag is dropped while the core cannot respond.

A violation monitor reports three kinds of illegal activity as a one-cycle code. The first is bus activity during Deep Sleep or relock. The second is an asynchronous bus event while the sleep request is still held in Sleep. The third is a core reset taken in Sleep whose sleep or clock-stop requests are not released by the next cycle.

Top module: `pwr_state_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters Stop-Grant (`state_o` = 0). After that edge `clk_en_o` = 1, `snoop_ok_o` = 1, `viol_o` = 0 and `viol_cause_o` = 0.
- R2: In Stop-Grant, `sleep_req_n` low at an edge moves `state_o` to Sleep (1) at that edge. The deep-sleep and clock-stop requests are ignored in Stop-Grant.
- R3: In Sleep, `sleep_req_n` high at an edge returns the block to Stop-Grant (0). This takes priority over a deep-sleep request sampled at the same edge.
- R4: In Sleep with `sleep_req_n` low, `deep_req_n` low at an edge moves the block to Deep Sleep (2). Deep Sleep is reachable from no other state.
- R5: If `clkstop_req_n` is low in Deep Sleep, `clk_en_o` falls exactly GATE_DLY edges after the entry edge. GATE_DLY is 1 or 2. With `clkstop_req_n` high, the enable stays on.
- R6: In Deep Sleep, `deep_req_n` high at an edge moves the block to relock (3). Sleep (1) is reported exactly RELOCK_CYCLES edges after that exit edge.
- R7: After a Deep Sleep exit in which the clock was gated, `clk_en_o` returns to 1 exactly RESTART_DLY edges after the exit edge.
- R8: `snoop_ok_o` is 0 in Deep Sleep and relock, and 1 in Stop-Grant and Sleep.
- R9: `bus_act` high at an edge while in Deep Sleep or relock gives `viol_cause_o` = 1 and `viol_o` = 1 for the cycle after that edge only.
- R10: `bus_act` high at an edge in Sleep with `sleep_req_n` still low gives `viol_cause_o` = 2. `bus_act` in Stop-Grant raises no violation.
- R11: `core_rst_n` low at an edge while in Sleep arms a check for the next edge. If `sleep_req_n` or `clkstop_req_n` is still low at that next edge, `viol_cause_o` = 3, and this code has priority over the others.
- R12: `core_rst_n` low at an edge forces Stop-Grant from any state, with `clk_en_o` = 1 after that edge and any relock or restart timing abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous block reset, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| deep_req_n | input | 1 | Deep-sleep request, active low |
| clkstop_req_n | input | 1 | Bus-clock stop request, active low |
| core_rst_n | input | 1 | Core reset request, active low |
| bus_act | input | 1 | Pulse marking an input transition or asynchronous bus event |
| state_o | output | 2 | 0 Stop-Grant, 1 Sleep, 2 Deep Sleep, 3 relock |
| clk_en_o | output | 1 | Bus-clock gate enable |
| snoop_ok_o | output | 1 | Snoops and interrupts may be accepted |
| viol_o | output | 1 | One-cycle protocol violation pulse |
| viol_cause_o | output | 2 | 0 none, 1 bus in deep/relock, 2 bus in sleep, 3 reset sequence |

## Verification
A wrong state register shows at once on `state_o` and `snoop_ok_o`, in the cycle after the bad edge. An off-by-one relock or restart counter shows only at the end of its window: the bench walks every cycle of the relock interval and compares `state_o` and `clk_en_o` against the expected cycle number, so a one-cycle shift is caught in that exact cycle. A mistaken violation decode appears as a wrong `viol_cause_o` value one edge after the stimulus. A stuck flag appears one edge later, when the code fails to return to zero.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_GRANT  = 2'd0,
        PS_SLEEP  = 2'd1,
        PS_DEEP   = 2'd2,
        PS_RELOCK = 2'd3
    } pstate_e;

    typedef enum logic [1:0] {
        VC_NONE      = 2'd0,
        VC_BUS_DEEP  = 2'd1,
        VC_BUS_SLEEP = 2'd2,
        VC_RST_SEQ   = 2'd3
    } vcause_e;

endpackage

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
    import pwr_seq_pkg::*;
#(
    parameter int RELOCK_CYCLES = 3000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sleep_n,
    input  logic    deep_n,
    input  logic    core_rst_n,
    output pstate_e state_o,
    output logic    enter_deep_o,
    output logic    exit_deep_o
);
    localparam int RW = $clog2(RELOCK_CYCLES + 1);

    typedef struct packed {
        pstate_e        st;
        logic [RW-1:0]  rl;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic enter_d, exit_d;

    always_comb begin
        nxt_d   = cur_q;
        enter_d = 1'b0;
        exit_d  = 1'b0;
        if (!core_rst_n) begin
            nxt_d.st = PS_GRANT;
            nxt_d.rl = '0;
        end else begin
            unique case (cur_q.st)
                PS_GRANT: begin
                    if (!sleep_n) nxt_d.st = PS_SLEEP;
                end
                PS_SLEEP: begin
                    if (sleep_n) begin
                        nxt_d.st = PS_GRANT;
                    end else if (!deep_n) begin
                        nxt_d.st = PS_DEEP;
                        enter_d  = 1'b1;
                    end
                end
                PS_DEEP: begin
                    if (deep_n) begin
                        nxt_d.st = PS_RELOCK;
                        nxt_d.rl = RW'(RELOCK_CYCLES - 1);
                        exit_d   = 1'b1;
                    end
                end
                PS_RELOCK: begin
                    if (cur_q.rl == '0) nxt_d.st = PS_SLEEP;
                    else                nxt_d.rl = cur_q.rl - RW'(1);
                end
                default: nxt_d.st = PS_GRANT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st <= PS_GRANT;
            cur_q.rl <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o      = cur_q.st;
    assign enter_deep_o = enter_d;
    assign exit_deep_o  = exit_d;

    // checker: cycles spent in relock, counted independently of rl
    logic [RW-1:0] dwell_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                                     dwell_q <= '0;
        else if (cur_q.st != PS_RELOCK)                 dwell_q <= '0;
        else if (dwell_q != {RW{1'b1}})                 dwell_q <= dwell_q + RW'(1);
    end

    assert_deep_only_from_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == PS_DEEP && $past(cur_q.st) != PS_DEEP) |-> $past(cur_q.st) == PS_SLEEP);

    assert_relock_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == PS_SLEEP && $past(cur_q.st) == PS_RELOCK) |-> dwell_q == RW'(RELOCK_CYCLES));

endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
    import pwr_seq_pkg::*;
#(
    parameter int GATE_DLY    = 2,
    parameter int RESTART_DLY = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    core_rst_n,
    input  pstate_e state_i,
    input  logic    stop_n,
    input  logic    enter_i,
    input  logic    exit_i,
    output logic    clk_en_o
);
    localparam int MAXD = (GATE_DLY > RESTART_DLY) ? GATE_DLY : RESTART_DLY;
    localparam int CW   = $clog2(MAXD + 2);

    typedef struct packed {
        logic          en;
        logic [CW-1:0] cnt;
    } gate_t;

    gate_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!core_rst_n) begin
            nxt_d.en  = 1'b1;
            nxt_d.cnt = '0;
        end else if (enter_i) begin
            nxt_d.en  = 1'b1;
            nxt_d.cnt = CW'(GATE_DLY - 1);
        end else if (exit_i) begin
            nxt_d.cnt = CW'(RESTART_DLY - 1);
        end else begin
            unique case (state_i)
                PS_DEEP: begin
                    if (cur_q.cnt != '0)  nxt_d.cnt = cur_q.cnt - CW'(1);
                    else if (!stop_n)     nxt_d.en  = 1'b0;
                end
                PS_RELOCK: begin
                    if (cur_q.cnt != '0)  nxt_d.cnt = cur_q.cnt - CW'(1);
                    else                  nxt_d.en  = 1'b1;
                end
                default: begin
                    nxt_d.en  = 1'b1;
                    nxt_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.en  <= 1'b1;
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign clk_en_o = cur_q.en;

    // checker counters
    logic [1:0]    stop_dwell_q;
    logic [CW-1:0] since_exit_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_dwell_q <= '0;
            since_exit_q <= '0;
        end else begin
            if (state_i == PS_DEEP && !stop_n)
                stop_dwell_q <= (stop_dwell_q == 2'd3) ? 2'd3 : stop_dwell_q + 2'd1;
            else
                stop_dwell_q <= '0;
            if (exit_i)
                since_exit_q <= '0;
            else if (state_i == PS_RELOCK && since_exit_q != {CW{1'b1}})
                since_exit_q <= since_exit_q + CW'(1);
        end
    end

    assert_gate_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(stop_dwell_q) >= GATE_DLY) |-> !cur_q.en);

    assert_restart_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cur_q.en) && state_i == PS_RELOCK) |-> since_exit_q == CW'(RESTART_DLY));

endmodule

// File: rtl/pwr_viol_mon.sv
module pwr_viol_mon
    import pwr_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    core_rst_n,
    input  pstate_e state_i,
    input  logic    sleep_n,
    input  logic    stop_n,
    input  logic    bus_act,
    output vcause_e cause_o
);
    typedef struct packed {
        vcause_e cause;
        logic    rst_chk;
    } mon_t;

    mon_t cur_q, nxt_d;

    always_comb begin
        nxt_d.rst_chk = !core_rst_n && (state_i == PS_SLEEP);
        if (cur_q.rst_chk && (!sleep_n || !stop_n))
            nxt_d.cause = VC_RST_SEQ;
        else if (bus_act && (state_i == PS_DEEP || state_i == PS_RELOCK))
            nxt_d.cause = VC_BUS_DEEP;
        else if (bus_act && state_i == PS_SLEEP && !sleep_n)
            nxt_d.cause = VC_BUS_SLEEP;
        else
            nxt_d.cause = VC_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.cause   <= VC_NONE;
            cur_q.rst_chk <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cause_o = cur_q.cause;

    assert_bus_in_deep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_act && state_i == PS_DEEP) |=> cur_q.cause != VC_NONE);

    assert_reset_seq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.rst_chk && !sleep_n) |=> cur_q.cause == VC_RST_SEQ);

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
    import pwr_seq_pkg::*;
#(
    parameter int RELOCK_CYCLES = 3000,
    parameter int GATE_DLY      = 2,
    parameter int RESTART_DLY   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req_n,
    input  logic       deep_req_n,
    input  logic       clkstop_req_n,
    input  logic       core_rst_n,
    input  logic       bus_act,
    output logic [1:0] state_o,
    output logic       clk_en_o,
    output logic       snoop_ok_o,
    output logic       viol_o,
    output logic [1:0] viol_cause_o
);
    pstate_e st;
    vcause_e cause;
    logic    enter_deep, exit_deep;

    pwr_state_fsm #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_n      (sleep_req_n),
        .deep_n       (deep_req_n),
        .core_rst_n   (core_rst_n),
        .state_o      (st),
        .enter_deep_o (enter_deep),
        .exit_deep_o  (exit_deep)
    );

    pwr_clk_gate #(.GATE_DLY(GATE_DLY), .RESTART_DLY(RESTART_DLY)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_rst_n (core_rst_n),
        .state_i    (st),
        .stop_n     (clkstop_req_n),
        .enter_i    (enter_deep),
        .exit_i     (exit_deep),
        .clk_en_o   (clk_en_o)
    );

    pwr_viol_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_rst_n (core_rst_n),
        .state_i    (st),
        .sleep_n    (sleep_req_n),
        .stop_n     (clkstop_req_n),
        .bus_act    (bus_act),
        .cause_o    (cause)
    );

    always_comb begin
        state_o      = st;
        snoop_ok_o   = (st == PS_GRANT) || (st == PS_SLEEP);
        viol_cause_o = cause;
        viol_o       = (cause != VC_NONE);
    end

    assert_no_snoop_in_deep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_deep && core_rst_n) |=> !snoop_ok_o);

endmodule

// File: tb/tb_pwr_state_seq.sv
module tb_pwr_state_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RL  = 12;
    localparam int GD  = 2;
    localparam int RD  = 4;

    logic clk = 1'b0;
    logic rst_n, sleep_req_n, deep_req_n, clkstop_req_n, core_rst_n, bus_act;
    logic [1:0] state_o, viol_cause_o;
    logic clk_en_o, snoop_ok_o, viol_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_state_seq #(.RELOCK_CYCLES(RL), .GATE_DLY(GD), .RESTART_DLY(RD)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_req_n(sleep_req_n), .deep_req_n(deep_req_n),
        .clkstop_req_n(clkstop_req_n), .core_rst_n(core_rst_n), .bus_act(bus_act),
        .state_o(state_o), .clk_en_o(clk_en_o), .snoop_ok_o(snoop_ok_o),
        .viol_o(viol_o), .viol_cause_o(viol_cause_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; sleep_req_n = 1; deep_req_n = 1; clkstop_req_n = 1;
        core_rst_n = 1; bus_act = 0;
        tick(); tick();
        // R1 reset state
        chk("R1 state", state_o, 0);
        chk("R1 clk_en", clk_en_o, 1);
        chk("R1 snoop", snoop_ok_o, 1);
        chk("R1 viol", viol_o, 0);
        chk("R1 cause", viol_cause_o, 0);
        rst_n = 1;
        tick();

        // R2 / R10: deep and stop requests and bus activity ignored in Stop-Grant
        for (int m = 0; m < 4; m++) begin
            deep_req_n = m[0]; clkstop_req_n = m[1]; bus_act = 1;
            tick();
            chk("R2 grant holds", state_o, 0);
            chk("R10 no viol in grant", viol_cause_o, 0);
        end
        deep_req_n = 1; clkstop_req_n = 1; bus_act = 0;
        tick();

        sleep_req_n = 0; tick();
        chk("R2 enter sleep", state_o, 1);
        chk("R8 snoop in sleep", snoop_ok_o, 1);

        // R3 priority of sleep release over deep request
        sleep_req_n = 1; deep_req_n = 0; tick();
        chk("R3 back to grant", state_o, 0);
        deep_req_n = 1;
        sleep_req_n = 0; tick();
        chk("R2 sleep again", state_o, 1);

        // R10 bus event with sleep held
        bus_act = 1; tick(); bus_act = 0;
        chk("R10 cause", viol_cause_o, 2);
        tick();
        chk("R9 pulse ends", viol_o, 0);

        // R5 deep without clock stop keeps clock
        deep_req_n = 0; tick();
        chk("R4 deep entry", state_o, 2);
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk("R5 clock held without stop", clk_en_o, 1);
        end
        deep_req_n = 1; tick();
        chk("R6 relock", state_o, 3);
        for (int k = 1; k <= RL; k++) tick();
        chk("R6 sleep after relock", state_o, 1);

        // R5 gated entry
        deep_req_n = 0; clkstop_req_n = 0; tick();
        chk("R4 deep", state_o, 2);
        chk("R8 no snoop in deep", snoop_ok_o, 0);
        chk("R5 clk on at entry", clk_en_o, 1);
        for (int k = 1; k <= 4; k++) begin
            tick();
            chk("R5 gate timing", clk_en_o, (k >= GD) ? 0 : 1);
        end
        bus_act = 1; tick(); bus_act = 0;
        chk("R9 cause deep", viol_cause_o, 1);
        chk("R9 viol", viol_o, 1);

        // R6 R7 exit and relock walk
        deep_req_n = 1; clkstop_req_n = 1; tick();
        chk("R6 relock entry", state_o, 3);
        chk("R7 clock off at exit", clk_en_o, 0);
        chk("R8 no snoop in relock", snoop_ok_o, 0);
        for (int k = 1; k <= RL + 1; k++) begin
            tick();
            chk("R6 relock walk", state_o, (k < RL) ? 3 : 1);
            chk("R7 restart walk", clk_en_o, (k >= RD) ? 1 : 0);
        end

        // R9 in relock, then R12 reset from relock
        deep_req_n = 0; clkstop_req_n = 0; tick();
        tick(); tick(); tick();
        deep_req_n = 1; clkstop_req_n = 1; tick();
        bus_act = 1; tick(); bus_act = 0;
        chk("R9 cause relock", viol_cause_o, 1);
        core_rst_n = 0; tick();
        chk("R12 grant from relock", state_o, 0);
        chk("R12 clk on", clk_en_o, 1);
        core_rst_n = 1; tick();
        chk("R11 no check outside sleep", viol_cause_o, 0);
        chk("R2 sleep after reset", state_o, 1);

        // R11 sleep still held
        core_rst_n = 0; tick();
        chk("R12 grant from sleep", state_o, 0);
        core_rst_n = 1; tick();
        chk("R11 sleep held", viol_cause_o, 3);
        tick();
        chk("R11 clears", viol_cause_o, 0);

        // R11 released promptly
        core_rst_n = 0; tick();
        core_rst_n = 1; sleep_req_n = 1; tick();
        chk("R11 clean release", viol_cause_o, 0);

        // R11 clock stop held
        sleep_req_n = 0; tick();
        core_rst_n = 0; tick();
        core_rst_n = 1; sleep_req_n = 1; clkstop_req_n = 0; tick();
        chk("R11 stop held", viol_cause_o, 3);
        clkstop_req_n = 1; tick();

        // R12 from deep with clock gated
        sleep_req_n = 0; tick();
        deep_req_n = 0; clkstop_req_n = 0; tick(); tick(); tick();
        chk("R5 gated before reset", clk_en_o, 0);
        core_rst_n = 0; tick();
        chk("R12 grant from deep", state_o, 0);
        chk("R12 clk restored", clk_en_o, 1);
        chk("R12 snoop", snoop_ok_o, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule